// File: doc/BRIEF.md
# Page-Table DMA Address Translator

This block sits between a DMA-capable device and the system address space and turns each device bus address into a physical address. It does this through an on-chip table of 64-bit translation entries. Each entry holds the physical base of one page, and its two lowest bits give the access rights. The page size is a power of two, and the table covers a window whose start address, page size and entry count software programs with one enable pulse. A disable pulse tears the window down again.

A request carries a 64-bit table handle, a bus address and a read/write flag. One cycle later the block returns a registered result with these parts:

- the window-relative page address;
- the translated page base;
- the offset mask of the page;
- the physical address with the in-page offset merged in;
- the permission code;
- a fault flag.

A request that misses the window, or that names the wrong table, gets no translation. In that case the block returns an all-ones offset mask and zero permission. Entries are written through a separate load port, indexed by entry number.

Top module: `tce_dma_xlate`

## Requirements
- R1: After reset the window is disabled (entry count 0) and every table entry is zero. A request before any enable returns a no-translation result. A page of a freshly enabled window that was never loaded returns permission 0 and a fault, with `rsp_nomap` low.
- R2: Bits [1:0] of an entry encode permission: 0 no access, 1 read only, 2 write only, 3 read and write. `rsp_perm` carries that code. A read (`req_write`=0) faults unless bit 0 is set. A write faults unless bit 1 is set.
- R3: The entry index is (`req_addr` − window base) >> page shift, computed modulo 2^ADDR_W. The request is inside the window only when that index is below the entry count. An address below the base wraps to a large index and falls outside.
- R4: For an in-window request, `rsp_mask` = 2^shift − 1 and `rsp_xlat` = entry bits [ADDR_W-1:0] with the low shift bits cleared. `rsp_iova` = (`req_addr` − base) with the low shift bits cleared, and `rsp_phys` = `rsp_xlat` | (`req_addr` & `rsp_mask`).
- R5: A request with no translation gives `rsp_nomap`=1, `rsp_fault`=1 and `rsp_perm`=0. It also gives `rsp_xlat`, `rsp_iova` and `rsp_phys` all zero, and an all-ones `rsp_mask`.
- R6: An enable pulse loads base, shift and count only when the window is disabled, the count is between 1 and DEPTH, and the shift is between MIN_SHIFT (12) and MAX_SHIFT (30). Otherwise it is ignored, including an enable while a window is already active.
- R7: A disable pulse sets count, base and shift to zero and clears every entry. After a later enable, all pages read back as permission 0.
- R8: A load writes `ld_entry` at `ld_index` only when the index is below the current entry count. Loads while disabled or beyond the count are ignored.
- R9: A request is accepted only when `req_handle`[63:32] is zero and `req_handle`[31:0] equals TABLE_ID (default 0x0A10). Any other handle gives the R5 result.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise. The result fields change only on a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Enable pulse: set up the window |
| cfg_disable | input | 1 | Disable pulse: tear down window, clear entries |
| cfg_base | input | ADDR_W | Window start bus address |
| cfg_shift | input | SHIFT_W | Page shift (log2 of page size) |
| cfg_count | input | CNT_W | Number of table entries |
| ld_valid | input | 1 | Entry load strobe |
| ld_index | input | IDX_W | Entry number to load |
| ld_entry | input | ENTRY_W | Entry value |
| req_valid | input | 1 | Lookup strobe |
| req_handle | input | 64 | Table handle of the request |
| req_addr | input | ADDR_W | Device bus address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_nomap | output | 1 | No translation (outside window or bad handle) |
| rsp_fault | output | 1 | Access refused |
| rsp_perm | output | 2 | Permission code of the entry |
| rsp_iova | output | ADDR_W | Window-relative page address |
| rsp_xlat | output | ADDR_W | Translated page base |
| rsp_mask | output | ADDR_W | In-page offset mask |
| rsp_phys | output | ADDR_W | Final physical address |

## Verification
The hardest state to reach from the ports is a table that has held live entries and has then been wiped by a disable. Loads are refused while the window is down, so stale contents can only be seen by following a fixed sequence: enable, load, translate, disable, re-enable with a different page size, then read the same index back. The bench walks exactly that sequence and expects zero permission and a 64 KiB mask. It also reaches the wraparound case, where an address just below the window base becomes a huge index, and a handle whose low word matches but whose upper word is non-zero.

// File: rtl/tce_pkg.sv
package tce_pkg;

   typedef enum logic [1:0] {
      PERM_NONE = 2'd0,
      PERM_RD   = 2'd1,
      PERM_WR   = 2'd2,
      PERM_RDWR = 2'd3
   } perm_e;

   // read needs bit 0, write needs bit 1
   function automatic logic perm_allows(input logic [1:0] perm, input logic is_write);
      return is_write ? perm[1] : perm[0];
   endfunction

endpackage

// File: rtl/tce_window_ctl.sv
module tce_window_ctl #(
   parameter int ADDR_W    = 48,
   parameter int DEPTH     = 64,
   parameter int CNT_W     = 7,
   parameter int SHIFT_W   = 6,
   parameter int MIN_SHIFT = 12,
   parameter int MAX_SHIFT = 30
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_req,
   input  logic               dis_req,
   input  logic [ADDR_W-1:0]  en_base,
   input  logic [SHIFT_W-1:0] en_shift,
   input  logic [CNT_W-1:0]   en_count,
   output logic [ADDR_W-1:0]  win_base,
   output logic [SHIFT_W-1:0] win_shift,
   output logic [CNT_W-1:0]   win_count,
   output logic               tbl_clear
);

   localparam logic [SHIFT_W-1:0] LO_S  = SHIFT_W'(MIN_SHIFT);
   localparam logic [SHIFT_W-1:0] HI_S  = SHIFT_W'(MAX_SHIFT);
   localparam logic [CNT_W-1:0]   MAX_C = CNT_W'(DEPTH);

   logic win_idle;
   logic shift_ok;
   logic count_ok;
   logic take_en;

   assign win_idle  = (win_count == '0);
   assign shift_ok  = (en_shift >= LO_S) && (en_shift <= HI_S);
   assign count_ok  = (en_count != '0) && (en_count <= MAX_C);
   assign take_en   = en_req && !dis_req && win_idle && shift_ok && count_ok;
   assign tbl_clear = dis_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_base  <= '0;
         win_shift <= '0;
         win_count <= '0;
      end else if (dis_req) begin
         win_base  <= '0;
         win_shift <= '0;
         win_count <= '0;
      end else if (take_en) begin
         win_base  <= en_base;
         win_shift <= en_shift;
         win_count <= en_count;
      end
   end

   AST_DISABLE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      dis_req |=> (win_count == '0 && win_base == '0 && win_shift == '0)); // R7

   AST_ACTIVE_WINDOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (win_count != '0 && !dis_req) |=> ($stable(win_base) && $stable(win_shift) && $stable(win_count))); // R6

   AST_SHIFT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (win_count != '0) |-> (win_shift >= LO_S && win_shift <= HI_S && win_count <= MAX_C)); // R6

endmodule

// File: rtl/tce_entry_store.sv
module tce_entry_store #(
   parameter int ENTRY_W = 64,
   parameter int DEPTH   = 64,
   parameter int IDX_W   = 6,
   parameter int CNT_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr_req,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [CNT_W-1:0]   win_count,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [ENTRY_W-1:0] rd_data
);

   localparam bit POW2 = (DEPTH == (1 << IDX_W));

   logic [ENTRY_W-1:0] rows [DEPTH];
   logic               wr_ok;

   assign wr_ok = wr_req && ({1'b0, wr_idx} < {{(IDX_W + 1 - CNT_W){1'b0}}, win_count});

   for (genvar g = 0; g < DEPTH; g++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n)
            rows[g] <= '0;
         else if (clr)
            rows[g] <= '0;
         else if (wr_ok && (wr_idx == IDX_W'(g)))
            rows[g] <= wr_data;
      end

      AST_ROW_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> (rows[g] == '0)); // R7

      AST_LOAD_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_req && !clr && wr_idx == IDX_W'(g) && CNT_W'(g) >= win_count) |=> $stable(rows[g])); // R8
   end

   if (POW2) begin : g_rd_full
      assign rd_data = rows[rd_idx];
   end else begin : g_rd_guard
      assign rd_data = (rd_idx < IDX_W'(DEPTH)) ? rows[rd_idx] : '0;
   end

endmodule

// File: rtl/tce_lookup.sv
module tce_lookup #(
   parameter int ADDR_W  = 48,
   parameter int ENTRY_W = 64,
   parameter int IDX_W   = 6,
   parameter int CNT_W   = 7,
   parameter int SHIFT_W = 6
) (
   input  logic [ADDR_W-1:0]  win_base,
   input  logic [SHIFT_W-1:0] win_shift,
   input  logic [CNT_W-1:0]   win_count,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               handle_ok,
   output logic [IDX_W-1:0]   rd_idx,
   input  logic [ENTRY_W-1:0] entry,
   output logic               in_win,
   output logic [ADDR_W-1:0]  off_mask,
   output logic [ADDR_W-1:0]  rel_page,
   output logic [ADDR_W-1:0]  page_base,
   output logic [1:0]         perm
);

   logic [ADDR_W-1:0] rel;
   logic [ADDR_W-1:0] idx_full;
   logic [ADDR_W-1:0] pg_mask;
   logic [ADDR_W-1:0] unused_idx_hi;
   logic [ENTRY_W-1:0] unused_entry;

   assign rel      = addr - win_base;
   assign idx_full = rel >> win_shift;
   assign off_mask = (ADDR_W'(1) << win_shift) - ADDR_W'(1);
   assign pg_mask  = ~off_mask;
   assign in_win   = handle_ok && (idx_full < {{(ADDR_W - CNT_W){1'b0}}, win_count});
   assign rd_idx   = idx_full[IDX_W-1:0];
   assign rel_page = rel & pg_mask;
   assign page_base = entry[ADDR_W-1:0] & pg_mask;
   assign perm     = entry[1:0];

   assign unused_idx_hi = idx_full;
   assign unused_entry  = entry;

endmodule

// File: rtl/tce_dma_xlate.sv
module tce_dma_xlate
   import tce_pkg::*;
#(
   parameter int          ADDR_W       = 48,
   parameter int          ENTRY_W      = 64,
   parameter int          DEPTH        = 64,
   parameter int          MIN_SHIFT    = 12,
   parameter int          MAX_SHIFT    = 30,
   parameter logic [31:0] TABLE_ID     = 32'h0000_0A10,
   parameter bit          HANDLE_CHECK = 1'b1,
   localparam int         IDX_W        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int         CNT_W        = IDX_W + 1,
   localparam int         SHIFT_W      = $clog2(ADDR_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_enable,
   input  logic               cfg_disable,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [SHIFT_W-1:0] cfg_shift,
   input  logic [CNT_W-1:0]   cfg_count,
   input  logic               ld_valid,
   input  logic [IDX_W-1:0]   ld_index,
   input  logic [ENTRY_W-1:0] ld_entry,
   input  logic               req_valid,
   input  logic [63:0]        req_handle,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_write,
   output logic               rsp_valid,
   output logic               rsp_nomap,
   output logic               rsp_fault,
   output logic [1:0]         rsp_perm,
   output logic [ADDR_W-1:0]  rsp_iova,
   output logic [ADDR_W-1:0]  rsp_xlat,
   output logic [ADDR_W-1:0]  rsp_mask,
   output logic [ADDR_W-1:0]  rsp_phys
);

   // elaboration-time parameter checks
   if (ENTRY_W < ADDR_W) begin : g_bad_entry_w
      $error("ENTRY_W must be at least ADDR_W");
   end
   if (MAX_SHIFT >= ADDR_W || MIN_SHIFT > MAX_SHIFT || MIN_SHIFT < 2) begin : g_bad_shift
      $error("shift range must satisfy 2 <= MIN_SHIFT <= MAX_SHIFT < ADDR_W");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [ADDR_W-1:0]  win_base;
   logic [SHIFT_W-1:0] win_shift;
   logic [CNT_W-1:0]   win_count;
   logic               tbl_clear;
   logic [IDX_W-1:0]   rd_idx;
   logic [ENTRY_W-1:0] rd_entry;
   logic               handle_ok;
   logic               in_win;
   logic [ADDR_W-1:0]  off_mask;
   logic [ADDR_W-1:0]  rel_page;
   logic [ADDR_W-1:0]  page_base;
   logic [1:0]         perm;
   logic               r_write;

   if (HANDLE_CHECK) begin : g_handle_full
      assign handle_ok = (req_handle[63:32] == 32'h0) && (req_handle[31:0] == TABLE_ID);
   end else begin : g_handle_none
      logic [63:0] unused_handle;
      assign unused_handle = req_handle;
      assign handle_ok     = 1'b1;
   end

   tce_window_ctl #(
      .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W),
      .MIN_SHIFT(MIN_SHIFT), .MAX_SHIFT(MAX_SHIFT)
   ) i_window (
      .clk(clk), .rst_n(rst_n),
      .en_req(cfg_enable), .dis_req(cfg_disable),
      .en_base(cfg_base), .en_shift(cfg_shift), .en_count(cfg_count),
      .win_base(win_base), .win_shift(win_shift), .win_count(win_count),
      .tbl_clear(tbl_clear)
   );

   tce_entry_store #(
      .ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .clr(tbl_clear),
      .wr_req(ld_valid), .wr_idx(ld_index), .wr_data(ld_entry),
      .win_count(win_count), .rd_idx(rd_idx), .rd_data(rd_entry)
   );

   tce_lookup #(
      .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W)
   ) i_lookup (
      .win_base(win_base), .win_shift(win_shift), .win_count(win_count),
      .addr(req_addr), .handle_ok(handle_ok),
      .rd_idx(rd_idx), .entry(rd_entry),
      .in_win(in_win), .off_mask(off_mask), .rel_page(rel_page),
      .page_base(page_base), .perm(perm)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_nomap <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_perm  <= PERM_NONE;
         rsp_iova  <= '0;
         rsp_xlat  <= '0;
         rsp_mask  <= '0;
         rsp_phys  <= '0;
         r_write   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            r_write <= req_write;
            if (in_win) begin
               rsp_nomap <= 1'b0;
               rsp_fault <= !perm_allows(perm, req_write);
               rsp_perm  <= perm;
               rsp_iova  <= rel_page;
               rsp_xlat  <= page_base;
               rsp_mask  <= off_mask;
               rsp_phys  <= page_base | (req_addr & off_mask);
            end else begin
               rsp_nomap <= 1'b1;
               rsp_fault <= 1'b1;
               rsp_perm  <= PERM_NONE;
               rsp_iova  <= '0;
               rsp_xlat  <= '0;
               rsp_mask  <= '1;
               rsp_phys  <= '0;
            end
         end
      end
   end

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R10

   AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && $stable(rsp_phys) && $stable(rsp_perm))); // R10

   AST_NOMAP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_nomap) |-> (rsp_fault && rsp_perm == 2'd0 && &rsp_mask && rsp_phys == '0)); // R5

   AST_FAULT_MATCHES_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_nomap) |-> (rsp_fault == !(r_write ? rsp_perm[1] : rsp_perm[0]))); // R2

   AST_PHYS_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_nomap) |-> ((rsp_phys & ~rsp_mask) == rsp_xlat && (rsp_xlat & rsp_mask) == '0)); // R4

   AST_BAD_HANDLE_NOMAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && HANDLE_CHECK && req_handle[63:32] != 32'h0) |=> rsp_nomap); // R9

   AST_DISABLED_NOMAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && win_count == '0) |=> rsp_nomap); // R1

endmodule

// File: tb/test_tce_dma_xlate.sv
`timescale 1ns/1ps
module test_tce_dma_xlate;

   localparam int AW = 48;
   localparam logic [63:0] TID = 64'h0000_0000_0000_0A10;
   localparam logic [AW-1:0] ONES = {AW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_enable = 1'b0, cfg_disable = 1'b0;
   logic [AW-1:0] cfg_base = '0;
   logic [5:0]    cfg_shift = '0;
   logic [6:0]    cfg_count = '0;
   logic          ld_valid = 1'b0;
   logic [5:0]    ld_index = '0;
   logic [63:0]   ld_entry = '0;
   logic          req_valid = 1'b0;
   logic [63:0]   req_handle = '0;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic          rsp_valid, rsp_nomap, rsp_fault;
   logic [1:0]    rsp_perm;
   logic [AW-1:0] rsp_iova, rsp_xlat, rsp_mask, rsp_phys;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tce_dma_xlate i_tce_dma_xlate (
      .clk(clk), .rst_n(rst_n),
      .cfg_enable(cfg_enable), .cfg_disable(cfg_disable),
      .cfg_base(cfg_base), .cfg_shift(cfg_shift), .cfg_count(cfg_count),
      .ld_valid(ld_valid), .ld_index(ld_index), .ld_entry(ld_entry),
      .req_valid(req_valid), .req_handle(req_handle), .req_addr(req_addr), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_nomap(rsp_nomap), .rsp_fault(rsp_fault), .rsp_perm(rsp_perm),
      .rsp_iova(rsp_iova), .rsp_xlat(rsp_xlat), .rsp_mask(rsp_mask), .rsp_phys(rsp_phys)
   );

   typedef struct packed {
      logic [AW-1:0] addr;
      logic          wr;
      logic [AW-1:0] phys;
      logic [1:0]    perm;
      logic          fault;
      logic          nomap;
      logic [AW-1:0] mask;
   } vec_t;

   // window base 0x1000_0000, shift 12, 16 entries; entries 1,2,3,15 loaded
   localparam vec_t VECS [11] = '{
      '{48'h0000_1000_1ABC, 1'b0, 48'h0012_3456_7ABC, 2'd1, 1'b0, 1'b0, 48'hFFF},  // R2 RO read
      '{48'h0000_1000_1ABC, 1'b1, 48'h0012_3456_7ABC, 2'd1, 1'b1, 1'b0, 48'hFFF},  // R2 RO write
      '{48'h0000_1000_2010, 1'b1, 48'h00AB_CDE0_0010, 2'd2, 1'b0, 1'b0, 48'hFFF},  // R2 WO write
      '{48'h0000_1000_2010, 1'b0, 48'h00AB_CDE0_0010, 2'd2, 1'b1, 1'b0, 48'hFFF},  // R2 WO read
      '{48'h0000_1000_3FFF, 1'b0, 48'h0055_5500_0FFF, 2'd3, 1'b0, 1'b0, 48'hFFF},  // R4 RW
      '{48'h0000_1000_3000, 1'b1, 48'h0055_5500_0000, 2'd3, 1'b0, 1'b0, 48'hFFF},  // R4
      '{48'h0000_1000_0123, 1'b0, 48'h0000_0000_0123, 2'd0, 1'b1, 1'b0, 48'hFFF},  // R2 perm 0
      '{48'h0000_1000_F008, 1'b1, 48'h8000_0000_0008, 2'd3, 1'b0, 1'b0, 48'hFFF},  // R3 last entry
      '{48'h0000_1001_0000, 1'b0, 48'h0,             2'd0, 1'b1, 1'b1, ONES},     // R3 R5 one past end
      '{48'h0000_0FFF_FFFF, 1'b1, 48'h0,             2'd0, 1'b1, 1'b1, ONES},     // R3 R5 below base
      '{48'h0000_1000_4000, 1'b0, 48'h0,             2'd0, 1'b1, 1'b0, 48'hFFF}   // R1 unloaded entry
   };

   task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_en(input logic [AW-1:0] b, input logic [5:0] s, input logic [6:0] c);
      @(negedge clk);
      cfg_enable = 1'b1; cfg_base = b; cfg_shift = s; cfg_count = c;
      @(negedge clk);
      cfg_enable = 1'b0;
   endtask

   task automatic cfg_dis();
      @(negedge clk);
      cfg_disable = 1'b1;
      @(negedge clk);
      cfg_disable = 1'b0;
   endtask

   task automatic load(input logic [5:0] idx, input logic [63:0] e);
      @(negedge clk);
      ld_valid = 1'b1; ld_index = idx; ld_entry = e;
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   // result is registered at the edge after the strobe; sampled at the following negedge
   task automatic lookup(input logic [63:0] h, input logic [AW-1:0] a, input logic w);
      @(negedge clk);
      req_valid = 1'b1; req_handle = h; req_addr = a; req_write = w;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [159:0] pack_rsp();
      return {rsp_valid, rsp_phys, rsp_perm, rsp_fault, rsp_nomap, rsp_mask};
   endfunction

   function automatic logic [159:0] pack_exp(input logic [AW-1:0] p, input logic [1:0] pm,
                                             input logic f, input logic nm, input logic [AW-1:0] m);
      return {1'b1, p, pm, f, nm, m};
   endfunction

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 R10 rsp_valid after reset", {159'h0, rsp_valid}, 160'h0);

      lookup(TID, 48'h0000_1000_0000, 1'b0);
      chk("R1 R5 lookup while disabled", pack_rsp(), pack_exp(48'h0, 2'd0, 1'b1, 1'b1, ONES));

      // load while disabled must be dropped
      load(6'd5, 64'h0000_0000_0000_FFF3);
      cfg_en(48'h0000_1000_0000, 6'd12, 7'd16);
      lookup(TID, 48'h0000_1000_5000, 1'b0);
      chk("R8 load while disabled ignored", pack_rsp(), pack_exp(48'h0, 2'd0, 1'b1, 1'b0, 48'hFFF));

      load(6'd1, 64'h0000_0012_3456_7001);
      load(6'd2, 64'h0000_00AB_CDE0_0FF2);
      load(6'd3, 64'h0000_0055_5500_0003);
      load(6'd15, 64'h0000_8000_0000_0003);

      foreach (VECS[i]) begin
         lookup(TID, VECS[i].addr, VECS[i].wr);
         chk($sformatf("R2/R3/R4/R5 vector %0d", i), pack_rsp(),
             pack_exp(VECS[i].phys, VECS[i].perm, VECS[i].fault, VECS[i].nomap, VECS[i].mask));
      end

      lookup(TID, 48'h0000_1000_1ABC, 1'b0);
      chk("R4 iova and xlat", {64'h0, rsp_iova, rsp_xlat}, {64'h0, 48'h1000, 48'h0012_3456_7000});
      @(negedge clk);
      chk("R10 rsp_valid drops", {159'h0, rsp_valid}, 160'h0);

      // enable while active is ignored
      cfg_en(48'h0000_2000_0000, 6'd13, 7'd8);
      lookup(TID, 48'h0000_1000_1ABC, 1'b0);
      chk("R6 enable while active ignored", pack_rsp(),
          pack_exp(48'h0012_3456_7ABC, 2'd1, 1'b0, 1'b0, 48'hFFF));

      cfg_dis();
      lookup(TID, 48'h0000_1000_1ABC, 1'b0);
      chk("R7 disabled window gives no map", pack_rsp(), pack_exp(48'h0, 2'd0, 1'b1, 1'b1, ONES));

      cfg_en(48'h0000_4000_0000, 6'd31, 7'd4);
      lookup(TID, 48'h0000_4001_2345, 1'b0);
      chk("R6 shift above range ignored", pack_rsp(), pack_exp(48'h0, 2'd0, 1'b1, 1'b1, ONES));

      cfg_en(48'h0000_4000_0000, 6'd16, 7'd0);
      lookup(TID, 48'h0000_4000_0000, 1'b0);
      chk("R6 zero count ignored", pack_rsp(), pack_exp(48'h0, 2'd0, 1'b1, 1'b1, ONES));

      cfg_en(48'h0000_4000_0000, 6'd16, 7'd4);
      lookup(TID, 48'h0000_4001_2345, 1'b0);
      chk("R7 entries cleared after re-enable", pack_rsp(),
          pack_exp(48'h0000_0000_2345, 2'd0, 1'b1, 1'b0, 48'hFFFF));

      load(6'd1, 64'h0000_0777_1234_5673);
      lookup(TID, 48'h0000_4001_2345, 1'b1);
      chk("R4 R3 64K page translation", pack_rsp(),
          pack_exp(48'h0777_1234_2345, 2'd3, 1'b0, 1'b0, 48'hFFFF));
      chk("R4 64K iova", {112'h0, rsp_iova}, {112'h0, 48'h0000_0001_0000});

      lookup(TID, 48'h0000_4004_0000, 1'b0);
      chk("R3 index equal to count", pack_rsp(), pack_exp(48'h0, 2'd0, 1'b1, 1'b1, ONES));

      lookup(64'h0000_0001_0000_0A10, 48'h0000_4001_2345, 1'b0);
      chk("R9 upper handle bits set", pack_rsp(), pack_exp(48'h0, 2'd0, 1'b1, 1'b1, ONES));
      lookup(64'h0000_0000_0000_0A11, 48'h0000_4001_2345, 1'b0);
      chk("R9 wrong table id", pack_rsp(), pack_exp(48'h0, 2'd0, 1'b1, 1'b1, ONES));
      lookup(TID, 48'h0000_4001_2345, 1'b0);
      chk("R9 correct handle accepted", pack_rsp(),
          pack_exp(48'h0777_1234_2345, 2'd3, 1'b0, 1'b0, 48'hFFFF));

      // hold without request: fields unchanged
      repeat (2) @(negedge clk);
      chk("R10 result held", {rsp_valid, rsp_phys}, {1'b0, 48'h0777_1234_2345});

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule